// File: doc/BRIEF.md
# Discrepancy-Driven Fault Candidate Engine

This block narrows down which gate of a small combinational circuit has failed. It uses the results of a series of applied tests. For each primary output of the circuit, a configuration register holds a bitmask of the gates that can influence that output (its fan-in cone). For every test, the block receives the observed output vector, the expected output vector and a mask of the outputs that count. It then updates two running gate sets. The suspect set holds gates that could explain every discrepancy seen so far. The corroboration set holds gates that every agreeing output vouches for.

A diagnosis run begins with a `start` pulse. Tests follow, one per clock, and the final test carries `last`. In the cycle after the final test is sampled, `done` pulses for one cycle. At that point the block presents three results: the candidate gates (suspects that are not corroborated), how many there are, and whether the circuit showed no discrepancy at all. These results stay unchanged until the next run completes. Test generation, driving the circuit and capturing its outputs are done elsewhere.

Top module: `diag_candidate_engine`

## Requirements
- R1: A `start` pulse sets both running sets to all gates and clears the record of any earlier mismatch, so a following run depends only on its own tests.
- R2: A test in which every enabled observed bit equals its expected bit leaves both running sets unchanged.
- R3: On a test with at least one enabled mismatching output, the per-test suspect set is the bitwise AND of the cones of every mismatching output.
- R4: On the same test, the per-test corroboration set is the bitwise AND of the cones of every enabled matching output.
- R5: On a test with a mismatch, each running set is ANDed with its per-test set, so effects accumulate over all tests of a run.
- R6: At the end of a run, `candidates` equals the running suspects AND NOT the running corroborations, and `candidateCount` equals the number of ones in `candidates`.
- R7: `faultFree` is 1 after a run with no enabled mismatch in any test, and `candidates` is then zero; otherwise `faultFree` is 0.
- R8: A test whose enabled outputs all mismatch takes the whole gate set as its per-test corroboration set, which leaves the running corroboration set unchanged.
- R9: An output whose bit in `outEnable` is 0 counts as neither matching nor mismatching for that test.
- R10: `done` is high for exactly one cycle, the cycle after the clock edge that samples `testValid` with `last`. The outputs `candidates`, `candidateCount` and `faultFree` change only at that edge. Reset value of all results is zero.
- R11: Tests presented while no run is active (after reset, or after the last test of a run) have no effect on any result and do not raise `done`.
- R12: Writing `cfgCone` with `cfgWrite` high replaces the cone of output `cfgSel`. All tests sampled at later edges use the new cone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Write strobe for a cone register |
| cfgSel | input | 3 | Index of the output whose cone is written |
| cfgCone | input | 32 | Gate bitmask of that output's fan-in cone |
| start | input | 1 | Begins a diagnosis run |
| testValid | input | 1 | One test result is presented this cycle |
| observed | input | 8 | Captured output vector of the circuit |
| expected | input | 8 | Fault-free output vector for the same test |
| outEnable | input | 8 | Outputs taking part in this test's comparison |
| last | input | 1 | Marks the final test of the run |
| candidates | output | 32 | Gates that remain suspected and uncorroborated |
| candidateCount | output | 6 | Number of candidate gates |
| faultFree | output | 1 | No mismatch was seen in the run |
| done | output | 1 | One-cycle pulse when results are updated |

## Verification
The hardest case to reach is a running corroboration set that has been narrowed over several tests, combined with tests where only some outputs disagree. A single-test sweep never shows the interaction between accumulated suspects and corroborations. For this reason the stimulus adds multi-test runs with sparse, randomly chosen discrepancies and random enable masks, and it changes the cone configuration between batches of runs. Before the multi-test runs, an exhaustive sweep of all 256 mismatch patterns covers the per-test intersection, including the all-mismatch case in which corroboration must stay whole.

// File: rtl/diag_candidate_pkg.sv
package diag_candidate_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic initSets;   // load both running sets with all gates
    logic applyTest;  // fold the present test into the running sets
    logic finish;     // capture results from the updated sets
  } ctrlStrobes_t;

endpackage

// File: rtl/diag_candidate_ctrl.sv
module diag_candidate_ctrl
  import diag_candidate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         testValid,
  input  logic         last,
  output ctrlStrobes_t strobes,
  output logic         done
);

  logic running;

  always_comb begin
    strobes.initSets  = start;
    strobes.applyTest = running && testValid && !start;
    strobes.finish    = strobes.applyTest && last;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (start)
        running <= 1'b1;
      else if (strobes.finish)
        running <= 1'b0;
    end
  end

endmodule

// File: rtl/diag_candidate_datapath.sv
module diag_candidate_datapath
  import diag_candidate_pkg::*;
#(
  parameter int NUM_GATES = 32,
  parameter int NUM_OUTS  = 8,
  localparam int SEL_W    = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1,
  localparam int CNT_W    = $clog2(NUM_GATES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic                 cfgWrite,
  input  logic [SEL_W-1:0]     cfgSel,
  input  logic [NUM_GATES-1:0] cfgCone,
  input  logic [NUM_OUTS-1:0]  observed,
  input  logic [NUM_OUTS-1:0]  expected,
  input  logic [NUM_OUTS-1:0]  outEnable,
  output logic [NUM_GATES-1:0] candidates,
  output logic [CNT_W-1:0]     candidateCount,
  output logic                 faultFree
);

  logic [NUM_GATES-1:0] coneMem [NUM_OUTS];
  logic [NUM_GATES-1:0][NUM_OUTS-1:0] coneCol;  // per gate: which outputs see it

  logic [NUM_GATES-1:0] suspSet, corrSet;
  logic                 anyMis;

  logic [NUM_OUTS-1:0]  misVec, matchVec;
  logic [NUM_GATES-1:0] testSusp, testCorr;
  logic [NUM_GATES-1:0] suspNext, corrNext, candNext;
  logic                 hit, anyMisNext;

  // Transpose cone storage so each gate reduces over outputs
  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
      assign coneCol[g][o] = coneMem[o][g];
    end
    // A gate survives when every selected output has it in its cone
    assign testSusp[g] = &(~misVec   | coneCol[g]);
    assign testCorr[g] = &(~matchVec | coneCol[g]);
  end

  function automatic logic [CNT_W-1:0] popCount(input logic [NUM_GATES-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_GATES; i++)
      c = c + CNT_W'(v[i]);
    return c;
  endfunction

  always_comb begin
    misVec     = (observed ^ expected) & outEnable;
    matchVec   = ~(observed ^ expected) & outEnable;
    hit        = |misVec;
    suspNext   = hit ? (suspSet & testSusp) : suspSet;
    corrNext   = hit ? (corrSet & testCorr) : corrSet;
    anyMisNext = anyMis | hit;
    candNext   = suspNext & ~corrNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int o = 0; o < NUM_OUTS; o++)
        coneMem[o] <= '0;
    end else if (cfgWrite && (int'(cfgSel) < NUM_OUTS)) begin
      coneMem[cfgSel] <= cfgCone;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      suspSet        <= '1;
      corrSet        <= '1;
      anyMis         <= 1'b0;
      candidates     <= '0;
      candidateCount <= '0;
      faultFree      <= 1'b0;
    end else begin
      if (strobes.initSets) begin
        suspSet <= '1;
        corrSet <= '1;
        anyMis  <= 1'b0;
      end else if (strobes.applyTest) begin
        suspSet <= suspNext;
        corrSet <= corrNext;
        anyMis  <= anyMisNext;
      end
      if (strobes.finish) begin
        candidates     <= candNext;
        candidateCount <= popCount(candNext);
        faultFree      <= !anyMisNext;
      end
    end
  end

endmodule

// File: rtl/diag_candidate_engine.sv
module diag_candidate_engine
  import diag_candidate_pkg::*;
#(
  parameter int NUM_GATES = 32,
  parameter int NUM_OUTS  = 8,
  localparam int SEL_W    = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1,
  localparam int CNT_W    = $clog2(NUM_GATES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrite,
  input  logic [SEL_W-1:0]     cfgSel,
  input  logic [NUM_GATES-1:0] cfgCone,
  input  logic                 start,
  input  logic                 testValid,
  input  logic [NUM_OUTS-1:0]  observed,
  input  logic [NUM_OUTS-1:0]  expected,
  input  logic [NUM_OUTS-1:0]  outEnable,
  input  logic                 last,
  output logic [NUM_GATES-1:0] candidates,
  output logic [CNT_W-1:0]     candidateCount,
  output logic                 faultFree,
  output logic                 done
);

  ctrlStrobes_t strobes;

  diag_candidate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .testValid (testValid),
    .last      (last),
    .strobes   (strobes),
    .done      (done)
  );

  diag_candidate_datapath #(
    .NUM_GATES (NUM_GATES),
    .NUM_OUTS  (NUM_OUTS)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .cfgWrite       (cfgWrite),
    .cfgSel         (cfgSel),
    .cfgCone        (cfgCone),
    .observed       (observed),
    .expected       (expected),
    .outEnable      (outEnable),
    .candidates     (candidates),
    .candidateCount (candidateCount),
    .faultFree      (faultFree)
  );

endmodule

// File: rtl/diag_candidate_checker.sv
module diag_candidate_checker #(
  parameter int NUM_GATES = 32,
  localparam int CNT_W    = $clog2(NUM_GATES + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 testValid,
  input logic                 last,
  input logic [NUM_GATES-1:0] candidates,
  input logic [CNT_W-1:0]     candidateCount,
  input logic                 faultFree,
  input logic                 done
);

  // R10: done lasts a single cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: done only follows a sampled final test
  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(testValid && last));

  // R10: results move only together with done
  assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(candidates) |-> done);

  // R7: a clean run reports no candidate
  assert_clean_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultFree) |-> (candidates == '0));

  // R6: count agrees with the reported set
  assert_count_matches_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(candidateCount) == $countones(candidates)));

  // R1: a fresh start never yields done on the next cycle
  assert_start_no_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

endmodule

bind diag_candidate_engine diag_candidate_checker #(
  .NUM_GATES (NUM_GATES)
) u_checker (
  .clk            (clk),
  .rstN           (rstN),
  .start          (start),
  .testValid      (testValid),
  .last           (last),
  .candidates     (candidates),
  .candidateCount (candidateCount),
  .faultFree      (faultFree),
  .done           (done)
);

// File: tb/diag_candidate_engine_bench.sv
module diag_candidate_engine_bench;

  localparam int NG = 32;
  localparam int NO = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrite = 1'b0;
  logic [2:0]    cfgSel = '0;
  logic [NG-1:0] cfgCone = '0;
  logic          start = 1'b0;
  logic          testValid = 1'b0;
  logic [NO-1:0] observed = '0;
  logic [NO-1:0] expected = '0;
  logic [NO-1:0] outEnable = '0;
  logic          last = 1'b0;
  logic [NG-1:0] candidates;
  logic [5:0]    candidateCount;
  logic          faultFree;
  logic          done;

  diag_candidate_engine u_diag_candidate_engine (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSel(cfgSel),
    .cfgCone(cfgCone), .start(start), .testValid(testValid),
    .observed(observed), .expected(expected), .outEnable(outEnable),
    .last(last), .candidates(candidates), .candidateCount(candidateCount),
    .faultFree(faultFree), .done(done)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // Bench-side model state
  logic [NG-1:0] cone [NO];
  logic [NG-1:0] mSusp, mCorr, lastCand;
  bit            mAny;
  bit            lastFree;

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog run did not finish actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // R12: cone write through the config port
  task automatic writeCone(input int idx, input logic [NG-1:0] m);
    cfgWrite = 1'b1; cfgSel = 3'(idx); cfgCone = m;
    cone[idx] = m;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic startRun();
    start = 1'b1;
    mSusp = '1; mCorr = '1; mAny = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic modelStep(input logic [NO-1:0] o, e, en);
    logic [NO-1:0] mis, mat;
    logic [NG-1:0] ts, tc;
    mis = (o ^ e) & en;
    mat = ~(o ^ e) & en;
    if (mis != 0) begin
      ts = '1; tc = '1;
      for (int k = 0; k < NO; k++) begin
        if (mis[k]) ts = ts & cone[k];
        if (mat[k]) tc = tc & cone[k];
      end
      mSusp = mSusp & ts;
      mCorr = mCorr & tc;
      mAny  = 1'b1;
    end
  endtask

  task automatic doTest(input logic [NO-1:0] o, e, en, input bit isLast, input string req);
    logic [NG-1:0] expCand;
    testValid = 1'b1; observed = o; expected = e; outEnable = en; last = isLast;
    modelStep(o, e, en);
    @(negedge clk);
    testValid = 1'b0; last = 1'b0;
    if (isLast) begin
      expCand = mSusp & ~mCorr;
      checkEq("R10", "done after last", 32'(done), 32'd1);
      checkEq(req, "candidates", candidates, expCand);
      checkEq("R6", "candidateCount", 32'(candidateCount), 32'($countones(expCand)));
      checkEq("R7", "faultFree", 32'(faultFree), 32'(!mAny));
      lastCand = expCand; lastFree = !mAny;
      @(negedge clk);
      checkEq("R10", "done single cycle", 32'(done), 32'd0);
    end
  endtask

  initial begin
    logic [NG-1:0] expC;
    for (int k = 0; k < NO; k++) cone[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R10", "reset done", 32'(done), 32'd0);
    checkEq("R10", "reset candidates", candidates, 32'd0);
    checkEq("R10", "reset faultFree", 32'(faultFree), 32'd0);

    // R11: test before any start is ignored
    doTest(8'h00, 8'hFF, 8'hFF, 1'b0, "R11");
    testValid = 1'b1; last = 1'b1; observed = 8'h0F; expected = 8'h00; outEnable = 8'hFF;
    @(negedge clk);
    testValid = 1'b0; last = 1'b0;
    checkEq("R11", "no done while idle", 32'(done), 32'd0);
    checkEq("R11", "candidates untouched while idle", candidates, 32'd0);

    // R12: structured cones
    for (int k = 0; k < NO; k++)
      writeCone(k, (32'h9E3779B9 * (k + 1)) ^ (32'h000000FF << (k * 3)));

    // R3 R4 R8: exhaustive single-test sweep over mismatch patterns
    for (int p = 0; p < 256; p++) begin
      startRun();
      doTest(8'(p), 8'h00, 8'hFF, 1'b1, (p == 255) ? "R8" : "R3");
    end

    // R8: every enabled output mismatches, corroboration stays whole
    startRun();
    doTest(8'h05, 8'h00, 8'h05, 1'b1, "R8");
    checkEq("R8", "all-mismatch gives no candidate", candidates, 32'd0);

    // R9: masked output cannot mismatch
    startRun();
    doTest(8'h80, 8'h00, 8'h7F, 1'b1, "R9");
    checkEq("R9", "masked mismatch is fault-free", 32'(faultFree), 32'd1);

    // R2: an all-match test after a mismatch leaves the sets alone
    startRun();
    doTest(8'h03, 8'h01, 8'hFF, 1'b0, "R2");
    doTest(8'hA5, 8'hA5, 8'hFF, 1'b1, "R2");
    expC = (cone[1] & ~(cone[0] & cone[2] & cone[3] & cone[4] & cone[5] & cone[6] & cone[7]));
    checkEq("R2", "match test no update", candidates, expC);

    // R7: whole run without mismatch
    startRun();
    doTest(8'h11, 8'h11, 8'hFF, 1'b0, "R7");
    doTest(8'h22, 8'h22, 8'hFF, 1'b1, "R7");
    checkEq("R7", "clean run empty", candidates, 32'd0);

    // R11: test after the run ended is ignored
    testValid = 1'b1; last = 1'b1; observed = 8'hFF; expected = 8'h00; outEnable = 8'hFF;
    @(negedge clk);
    testValid = 1'b0; last = 1'b0;
    checkEq("R11", "no done after run end", 32'(done), 32'd0);
    checkEq("R11", "faultFree held after run end", 32'(faultFree), 32'(lastFree));

    // R5 R1 R12: multi-test runs with sparse faults, cones rewritten per batch
    for (int r = 0; r < 400; r++) begin
      if (r % 50 == 0)
        for (int k = 0; k < NO; k++)
          writeCone(k, $urandom() | $urandom());
      startRun();
      begin
        int n;
        n = 1 + ($urandom() % 5);
        for (int t = 0; t < n; t++) begin
          logic [NO-1:0] e, flip, en;
          e    = 8'($urandom());
          en   = 8'($urandom()) | 8'h01;
          flip = (($urandom() % 3) == 0) ? 8'($urandom() & $urandom()) : 8'h00;
          doTest(e ^ flip, e, en, (t == n - 1), (r % 50 == 0) ? "R12" : "R5");
        end
      end
    end

    // R1: a new run does not inherit earlier mismatches
    startRun();
    doTest(8'h40, 8'h40, 8'hFF, 1'b1, "R1");
    checkEq("R1", "fresh run fault-free", 32'(faultFree), 32'd1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule